// File: doc/BRIEF.md
# Side-Street Priority Traffic Controller

This block sequences the lamps at a crossing where a main road meets a minor side street. The main road holds green by default. A vehicle sensor on the side street asks for service, and the side street gets green only after the main road has had a full long interval of green. The side street keeps green while vehicles continue to arrive, up to the limit of the long interval. An orange phase of one short interval separates each change of right of way.

The phase is held in two register bits. Each bit has its own set term and its own clear term, built from the present phase, the sensor input and two elapsed flags. A single interval counter produces those flags. It restarts each time the phase changes, and it counts up to a long limit. Both interval lengths are parameters. Each road gets a registered one-hot lamp output with three levels.

Top module: `sidestreet_light_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the phase is forced to main-go and the interval counter is cleared. After that edge `main_lamp` shows green and `side_lamp` shows red.
- R2: In the main-go phase the controller moves to main-amber only at an edge where `side_vehicle` is high and the long flag is set. A sensor request without the long flag leaves the phase unchanged, and so does the long flag without a request.
- R3: The main-amber phase lasts exactly SHORT_CYCLES+1 clock cycles, whatever `side_vehicle` does, and then passes to side-go.
- R4: In the side-go phase the controller stays while `side_vehicle` is high and the long flag is clear. It leaves for side-amber at the first edge where `side_vehicle` is low or the long flag is set. With the sensor held high, side-go lasts LONG_CYCLES+1 cycles.
- R5: The side-amber phase lasts exactly SHORT_CYCLES+1 clock cycles, whatever `side_vehicle` does, and then returns to main-go.
- R6: The interval counter restarts on every phase change. Cycle counting begins after the restart edge. The short flag is set once the count reaches SHORT_CYCLES, and the long flag once it reaches LONG_CYCLES. Both flags stay set until the next phase change. So a request that arrives after a long quiet main-go period is served at the next edge.
- R7: The lamp code is 3-bit one-hot: bit 0 green, bit 1 orange, bit 2 red. The phases decode as follows. Main-go gives main green and side red. Main-amber gives main orange and side red. Side-go gives main red and side green. Side-amber gives main red and side orange. The lamp outputs are registered and show the phase that holds after the same edge.
- R8: Each road shows exactly one lamp in every cycle. The two roads never show green or orange at the same time.
- R9: The phase bits (first bit, second bit) visit only the cycle 00 (main-go), 01 (main-amber), 11 (side-go), 10 (side-amber), then back to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| side_vehicle | input | 1 | Side-street vehicle request, already synchronous and clean |
| main_lamp | output | 3 | Main-road lamp, one-hot: bit0 green, bit1 orange, bit2 red |
| side_lamp | output | 3 | Side-street lamp, same encoding |

## Verification
The assertions take `side_vehicle` to be a clean synchronous level that is valid at every rising edge. They also assume LONG_CYCLES is greater than SHORT_CYCLES and SHORT_CYCLES is at least one. The phase-step properties only hold under those conditions. The stimulus changes the sensor level only on falling clock edges and runs the controller with a short interval of 3 and a long interval of 8. A reset is applied in the middle of an amber phase to show that the counter clears. The sensor is toggled during both amber phases to show that it has no effect there.

// File: rtl/tlc_pkg.sv
`timescale 1ns/1ps
package tlc_pkg;

  typedef logic [1:0] phase_t;

  // Phase codes: bit order is (first bit, second bit); the set/clear terms depend on it.
  localparam phase_t PH_MAIN_GO   = 2'b00;
  localparam phase_t PH_MAIN_AMB  = 2'b01;
  localparam phase_t PH_SIDE_GO   = 2'b11;
  localparam phase_t PH_SIDE_AMB  = 2'b10;

  localparam int LAMP_W = 3;
  typedef logic [LAMP_W-1:0] lamp_t;

  localparam lamp_t LAMP_GREEN  = 3'b001;
  localparam lamp_t LAMP_ORANGE = 3'b010;
  localparam lamp_t LAMP_RED    = 3'b100;

  localparam int N_ROADS = 2;

  // road 0 is the main road, road 1 the side street
  function automatic lamp_t lamp_of(input phase_t ph, input logic road);
    lamp_t l;
    unique case (ph)
      PH_MAIN_GO:  l = road ? LAMP_RED    : LAMP_GREEN;
      PH_MAIN_AMB: l = road ? LAMP_RED    : LAMP_ORANGE;
      PH_SIDE_GO:  l = road ? LAMP_GREEN  : LAMP_RED;
      default:     l = road ? LAMP_ORANGE : LAMP_RED;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/tlc_interval_timer.sv
`timescale 1ns/1ps
module tlc_interval_timer #(
  parameter int SHORT_CYCLES = 3,
  parameter int LONG_CYCLES  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic short_done,
  output logic long_done
);
  localparam int CW = $clog2(LONG_CYCLES + 1);
  localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_CYCLES);
  localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_CYCLES);

  logic [CW-1:0] count_q;

  // saturating count of cycles since the last phase change
  always_ff @(posedge clk) begin
    if (rst || restart)
      count_q <= '0;
    else if (count_q != LONG_LIM)
      count_q <= count_q + 1'b1;
  end

  assign short_done = (count_q >= SHORT_LIM);
  assign long_done  = (count_q >= LONG_LIM);

  AST_LONG_NEEDS_SHORT: assert property (@(posedge clk) disable iff (rst)
    long_done |-> short_done); // R6
  AST_FLAG_PERSISTS: assert property (@(posedge clk) disable iff (rst)
    (short_done && !restart) |=> short_done); // R6
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!short_done && !long_done)); // R6

endmodule

// File: rtl/tlc_phase_logic.sv
`timescale 1ns/1ps
module tlc_phase_logic
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   side_vehicle,
  input  logic   short_done,
  input  logic   long_done,
  output phase_t phase_next,
  output logic   phase_move
);
  phase_t phase_q;
  logic   b1, b2;
  logic   set_b1, clr_b1, set_b2, clr_b2;

  assign b1 = phase_q[1];
  assign b2 = phase_q[0];

  // per-bit set / clear terms
  assign set_b1 = !b1 &&  b2 && short_done;
  assign clr_b1 =  b1 && !b2 && short_done;
  assign set_b2 = !b1 && !b2 && side_vehicle && long_done;
  assign clr_b2 =  b1 &&  b2 && (!side_vehicle || long_done);

  always_comb begin
    phase_next[1] = set_b1 ? 1'b1 : (clr_b1 ? 1'b0 : b1);
    phase_next[0] = set_b2 ? 1'b1 : (clr_b2 ? 1'b0 : b2);
    if (rst) phase_next = PH_MAIN_GO;
  end

  assign phase_move = (phase_next != phase_q);

  always_ff @(posedge clk) begin
    phase_q <= phase_next;
  end

  AST_MAIN_GO_WAITS: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_MAIN_GO && !(side_vehicle && long_done)) |=> phase_q == PH_MAIN_GO); // R2
  AST_MAIN_GO_LEAVES: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_MAIN_GO && side_vehicle && long_done) |=> phase_q == PH_MAIN_AMB); // R2
  AST_MAIN_AMB_STEP: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_MAIN_AMB) |=> (phase_q == PH_MAIN_AMB || phase_q == PH_SIDE_GO)); // R3
  AST_SIDE_GO_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SIDE_GO && side_vehicle && !long_done) |=> phase_q == PH_SIDE_GO); // R4
  AST_SIDE_GO_ENDS: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SIDE_GO && (!side_vehicle || long_done)) |=> phase_q == PH_SIDE_AMB); // R4
  AST_SIDE_AMB_STEP: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SIDE_AMB) |=> (phase_q == PH_SIDE_AMB || phase_q == PH_MAIN_GO)); // R5
  AST_AMBER_NO_SENSOR: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_MAIN_AMB || phase_q == PH_SIDE_AMB) && !short_done) |=> $stable(phase_q)); // R9

endmodule

// File: rtl/tlc_lamp_decode.sv
`timescale 1ns/1ps
module tlc_lamp_decode
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase_next,
  output lamp_t  main_lamp,
  output lamp_t  side_lamp
);
  lamp_t lamp_q [N_ROADS];

  for (genvar r = 0; r < N_ROADS; r++) begin : g_road
    always_ff @(posedge clk) begin
      if (rst) lamp_q[r] <= lamp_of(PH_MAIN_GO, 1'(r));
      else     lamp_q[r] <= lamp_of(phase_next, 1'(r));
    end
  end

  assign main_lamp = lamp_q[0];
  assign side_lamp = lamp_q[1];

  AST_MAIN_ONE_LAMP: assert property (@(posedge clk) disable iff (rst)
    $countones(main_lamp) == 1); // R8
  AST_SIDE_ONE_LAMP: assert property (@(posedge clk) disable iff (rst)
    $countones(side_lamp) == 1); // R8
  AST_NO_SHARED_RIGHT: assert property (@(posedge clk) disable iff (rst)
    !((main_lamp[0] || main_lamp[1]) && (side_lamp[0] || side_lamp[1]))); // R8

endmodule

// File: rtl/sidestreet_light_ctrl.sv
`timescale 1ns/1ps
module sidestreet_light_ctrl #(
  parameter int SHORT_CYCLES = 3,
  parameter int LONG_CYCLES  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       side_vehicle,
  output logic [2:0] main_lamp,
  output logic [2:0] side_lamp
);
  import tlc_pkg::*;

  logic   short_done, long_done, phase_move;
  phase_t phase_next;

  tlc_interval_timer #(
    .SHORT_CYCLES(SHORT_CYCLES),
    .LONG_CYCLES (LONG_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (phase_move),
    .short_done(short_done),
    .long_done (long_done)
  );

  tlc_phase_logic u_phase (
    .clk         (clk),
    .rst         (rst),
    .side_vehicle(side_vehicle),
    .short_done  (short_done),
    .long_done   (long_done),
    .phase_next  (phase_next),
    .phase_move  (phase_move)
  );

  tlc_lamp_decode u_lamps (
    .clk       (clk),
    .rst       (rst),
    .phase_next(phase_next),
    .main_lamp (main_lamp),
    .side_lamp (side_lamp)
  );

endmodule

// File: tb/sidestreet_light_ctrl_bench.sv
`timescale 1ns/1ps
module sidestreet_light_ctrl_bench;
  localparam int SHORT = 3;
  localparam int LONG  = 8;
  localparam logic [2:0] G = 3'b001, O = 3'b010, R = 3'b100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic side_vehicle = 1'b0;
  logic [2:0] main_lamp, side_lamp;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sidestreet_light_ctrl #(.SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG)) u_sidestreet_light_ctrl (
    .clk(clk), .rst(rst), .side_vehicle(side_vehicle),
    .main_lamp(main_lamp), .side_lamp(side_lamp)
  );

  // entry: {req, sensor, cycles, expected main, expected side}
  localparam int NV = 17;
  localparam logic [18:0] VEC [NV] = '{
    {4'd2, 1'b1, 8'd8,  G, R},  // R2 request without long flag: stay
    {4'd2, 1'b1, 8'd1,  O, R},  // R2 long flag reached: move
    {4'd3, 1'b1, 8'd3,  O, R},  // R3 amber still running
    {4'd3, 1'b1, 8'd1,  R, G},  // R3 amber ends after SHORT+1
    {4'd4, 1'b1, 8'd8,  R, G},  // R4 held by traffic
    {4'd4, 1'b1, 8'd1,  R, O},  // R4 long limit ends side green
    {4'd5, 1'b0, 8'd3,  R, O},  // R5 amber running
    {4'd5, 1'b0, 8'd1,  G, R},  // R5 back to main green
    {4'd2, 1'b0, 8'd20, G, R},  // R2 long flag alone: stay
    {4'd6, 1'b1, 8'd1,  O, R},  // R6 flag kept: served next edge
    {4'd3, 1'b0, 8'd4,  R, G},  // R3 sensor ignored in amber
    {4'd4, 1'b0, 8'd1,  R, O},  // R4 no traffic ends side green
    {4'd5, 1'b1, 8'd3,  R, O},  // R5 sensor ignored in amber
    {4'd5, 1'b1, 8'd1,  G, R},  // R5 return
    {4'd6, 1'b1, 8'd8,  G, R},  // R6 timer restarted on change
    {4'd2, 1'b0, 8'd1,  G, R},  // R2 no request
    {4'd9, 1'b1, 8'd1,  O, R}   // R9 cycle order repeats
  };

  task automatic chk(input int req, input logic [2:0] em, input logic [2:0] es);
    checks++;
    if (main_lamp !== em || side_lamp !== es) begin
      errors++;
      $display("FAIL R%0d: main=%b side=%b expected main=%b side=%b",
               req, main_lamp, side_lamp, em, es);
    end
    checks++;
    if ($countones(main_lamp) != 1 || $countones(side_lamp) != 1) begin // R7 R8
      errors++;
      $display("FAIL R8: main=%b side=%b expected one-hot each", main_lamp, side_lamp);
    end
  endtask

  task automatic run(input logic s, input int n);
    side_vehicle = s;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(1, G, R);                      // R1 reset state
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      run(VEC[i][14], int'(VEC[i][13:6]));
      chk(int'(VEC[i][18:15]), VEC[i][5:3], VEC[i][2:0]);
    end
    // now in main amber with the counter just restarted
    run(1'b1, 2);
    chk(3, O, R);                      // R3
    rst = 1'b1;
    @(negedge clk);
    chk(1, G, R);                      // R1 reset in mid amber
    rst = 1'b0;
    run(1'b1, LONG);
    chk(1, G, R);                      // R1 counter cleared by reset
    run(1'b1, 1);
    chk(2, O, R);                      // R2
    run(1'b1, SHORT + 1);
    chk(7, R, G);                      // R7 side green code
    run(1'b1, 3);
    chk(4, R, G);                      // R4 traffic keeps side green
    run(1'b0, 1);
    chk(4, R, O);                      // R4
    run(1'b0, SHORT + 1);
    chk(9, G, R);                      // R9 back to start
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule